// File: doc/BRIEF.md
# UART Break Sequence Transmitter

This block places a break on a UART transmit line in answer to a stop-transmit command. A break is a run of break characters, each one a full character time of zero bits. The character time follows the frame format in use: one start bit, the data bits, an optional parity bit and one or two stop bits. The break length is therefore set as a count of whole characters and not as a fixed number of bits.

The block runs on the system clock and advances on a one-cycle bit-rate tick supplied from outside. When the command is accepted, the block samples the break count and the frame format. It pulls the line low on the next bit tick and holds it low until the programmed number of characters has elapsed. It then releases the line to idle high and gives a single-cycle done pulse. A count of zero produces no break, only the done pulse. A command that arrives while a break is pending or under way is dropped.

Top module: `brk_tx`

## Requirements
- R1: After reset, and at any time no break is pending or under way, `txLine` is 1 (idle) and `donePulse` is 0.
- R2: With a nonzero `breakCount`, the command is taken on a clock edge where `stopCmd` is 1. The line is still high at the first `bitTick` that follows that edge and goes low on the clock edge of that tick. Exactly one tick is seen with the line high between the command and the start of the break.
- R3: The line stays low for exactly `breakCount` times the character length, counted in bit ticks seen while the line is low. The character length is 1 + `dataLen` + `parityEn` + (2 if `twoStop` is 1, else 1). `dataLen` is the plain binary number of data bits (5 to 14).
- R4: `donePulse` is 1 for exactly one clock cycle, on the same edge where the line returns high after the last break character. `txLine` is 1 whenever `donePulse` is 1.
- R5: With `breakCount` equal to 0, the line never goes low, and `donePulse` is 1 in the cycle right after the command edge.
- R6: A `stopCmd` that arrives while a break is pending (waiting for its first tick) or under way has no effect. The break keeps its length and produces one done pulse.
- R7: `breakCount`, `dataLen`, `parityEn` and `twoStop` are sampled at the command edge. Changing them during the break does not change its length.
- R8: `txLine` changes only on clock edges where `bitTick` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse per bit time |
| stopCmd | input | 1 | Stop-transmit command pulse that starts a break |
| breakCount | input | CNT_W | Number of break characters to send |
| dataLen | input | DLEN_W | Data bits per character, binary 5 to 14 |
| parityEn | input | 1 | 1 adds a parity bit to the character length |
| twoStop | input | 1 | 1 selects two stop bits, 0 selects one |
| txLine | output | 1 | Serial transmit line, high when idle |
| donePulse | output | 1 | One-cycle pulse when the break sequence ends |

## Verification
A bit counter that wraps at the wrong point, or a character counter that loads or steps wrongly, shows up as a low period of the wrong number of ticks. The bench sees this only when the line rises or the done pulse appears, up to one full break later. A control state stuck outside idle shows as a missing done pulse or a line that never rises, and the per-run timeout catches it within a few thousand cycles. A reloaded count after an ignored command shows as a longer break or a second done pulse. The bench sweeps all frame formats against small break counts, so that every character length appears at count boundaries one to three.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    IDLE_S  = 2'd0,
    ARMED_S = 2'd1,
    SEND_S  = 2'd2
  } brkState_t;

  // Strobes from control to datapath; at most one active per cycle.
  typedef struct packed {
    logic load;      // capture count and format
    logic startLow;  // pull line low, begin first character
    logic stepBit;   // advance one bit inside the break
    logic endBreak;  // release line, signal completion
    logic zeroDone;  // empty break: completion only
  } brkStrobes_t;

endpackage

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        stopCmd,
  input  logic        countZero,
  input  logic        lastBit,
  input  logic        lastChar,
  output brkStrobes_t strobes
);

  brkState_t state;
  brkState_t nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      IDLE_S: begin
        if (stopCmd) begin
          if (countZero) begin
            strobes.zeroDone = 1'b1;
          end else begin
            strobes.load = 1'b1;
            nextState    = ARMED_S;
          end
        end
      end
      ARMED_S: begin
        if (bitTick) begin
          strobes.startLow = 1'b1;
          nextState        = SEND_S;
        end
      end
      SEND_S: begin
        if (bitTick) begin
          if (lastBit && lastChar) begin
            strobes.endBreak = 1'b1;
            nextState        = IDLE_S;
          end else begin
            strobes.stepBit = 1'b1;
          end
        end
      end
      default: nextState = IDLE_S;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE_S;
    else       state <= nextState;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes)) else $error("more than one strobe active"); // R4
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (state != IDLE_S) && stopCmd |=> (state != IDLE_S) || $past(strobes.endBreak)) else $error("command disturbed a running break"); // R6
  AST_WAIT_FOR_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ARMED_S) && !bitTick |=> (state == ARMED_S)) else $error("left pending state without a tick"); // R2

endmodule

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DLEN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  brkStrobes_t       strobes,
  input  logic [CNT_W-1:0]  breakCount,
  input  logic [DLEN_W-1:0] dataLen,
  input  logic              parityEn,
  input  logic              twoStop,
  output logic              countZero,
  output logic              lastBit,
  output logic              lastChar,
  output logic              txLine,
  output logic              donePulse
);

  localparam int LEN_W = DLEN_W + 2;

  logic [LEN_W-1:0] charLen;
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] bitIdx;
  logic [CNT_W-1:0] charsLeft;

  // start + data + parity + stop(s)
  assign charLen = LEN_W'(dataLen) + LEN_W'(parityEn) + LEN_W'(twoStop) + LEN_W'(2);

  assign countZero = (breakCount == '0);
  assign lastBit   = (bitIdx == lenReg - LEN_W'(1));
  assign lastChar  = (charsLeft == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg    <= '0;
      charsLeft <= '0;
      bitIdx    <= '0;
    end else begin
      if (strobes.load) begin
        lenReg    <= charLen;
        charsLeft <= breakCount;
      end
      if (strobes.startLow) begin
        bitIdx <= '0;
      end else if (strobes.stepBit) begin
        if (lastBit) begin
          bitIdx    <= '0;
          charsLeft <= charsLeft - CNT_W'(1);
        end else begin
          bitIdx <= bitIdx + LEN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txLine    <= 1'b1;
      donePulse <= 1'b0;
    end else begin
      if (strobes.startLow)      txLine <= 1'b0;
      else if (strobes.endBreak) txLine <= 1'b1;
      donePulse <= strobes.endBreak | strobes.zeroDone;
    end
  end

  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txLine) |-> $past(bitTick)) else $error("line fell without a tick"); // R8
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txLine) |-> $past(bitTick)) else $error("line rose without a tick"); // R8
  AST_RISE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txLine) |-> donePulse) else $error("line released without done"); // R4
  AST_DONE_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> txLine) else $error("done while line low"); // R4
  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    !txLine |-> (bitIdx < lenReg) && (charsLeft != '0)) else $error("counter out of range"); // R3

endmodule

// File: rtl/brk_tx.sv
module brk_tx
  import brk_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DLEN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              stopCmd,
  input  logic [CNT_W-1:0]  breakCount,
  input  logic [DLEN_W-1:0] dataLen,
  input  logic              parityEn,
  input  logic              twoStop,
  output logic              txLine,
  output logic              donePulse
);

  brkStrobes_t strobes;
  logic        countZero;
  logic        lastBit;
  logic        lastChar;

  brk_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .stopCmd   (stopCmd),
    .countZero (countZero),
    .lastBit   (lastBit),
    .lastChar  (lastChar),
    .strobes   (strobes)
  );

  brk_datapath #(
    .CNT_W  (CNT_W),
    .DLEN_W (DLEN_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .bitTick    (bitTick),
    .strobes    (strobes),
    .breakCount (breakCount),
    .dataLen    (dataLen),
    .parityEn   (parityEn),
    .twoStop    (twoStop),
    .countZero  (countZero),
    .lastBit    (lastBit),
    .lastChar   (lastChar),
    .txLine     (txLine),
    .donePulse  (donePulse)
  );

endmodule

// File: tb/test_brk_tx.sv
module test_brk_tx;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int DLEN_W     = 4;
  localparam int TICK_DIV   = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              bitTick = 1'b0;
  logic              stopCmd = 1'b0;
  logic [CNT_W-1:0]  breakCount = '0;
  logic [DLEN_W-1:0] dataLen = 4'd8;
  logic              parityEn = 1'b0;
  logic              twoStop = 1'b0;
  logic              txLine;
  logic              donePulse;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int tickCnt = 0;

  // monitor state
  bit tracking = 1'b0;
  bit seenLow = 1'b0;
  int lowTicks = 0;
  int preTicks = 0;
  int doneCnt = 0;
  int badDone = 0;
  int riseNoDone = 0;
  int lateChange = 0;
  logic prevTx = 1'b1;
  logic prevTick = 1'b0;

  brk_tx #(.CNT_W(CNT_W), .DLEN_W(DLEN_W)) i_brk_tx (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .stopCmd(stopCmd),
    .breakCount(breakCount), .dataLen(dataLen), .parityEn(parityEn),
    .twoStop(twoStop), .txLine(txLine), .donePulse(donePulse)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles = cycles + 1;
    #1;
    tickCnt = (tickCnt == TICK_DIV - 1) ? 0 : tickCnt + 1;
    bitTick = (tickCnt == 0);
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (txLine !== prevTx && !prevTick) lateChange = lateChange + 1;
      if (tracking) begin
        if (bitTick && !txLine) lowTicks = lowTicks + 1;
        if (bitTick && txLine && !seenLow) preTicks = preTicks + 1;
        if (!txLine) seenLow = 1'b1;
        if (donePulse) doneCnt = doneCnt + 1;
      end
      if (donePulse && !txLine) badDone = badDone + 1;
      if (txLine && !prevTx && !donePulse) riseNoDone = riseNoDone + 1;
    end
    prevTx   = txLine;
    prevTick = bitTick;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseCmd();
    @(posedge clk); #2;
    stopCmd = 1'b1;
    @(posedge clk); #2;
    stopCmd = 1'b0;
  endtask

  // mode 0 plain, 1 extra commands during break, 2 inputs changed during break
  task automatic runBreak(input int n, input int dl, input int p, input int s, input int mode);
    int expLen;
    int guard;
    expLen = 1 + dl + p + (s != 0 ? 2 : 1);
    @(posedge clk); #2;
    breakCount = CNT_W'(n);
    dataLen    = DLEN_W'(dl);
    parityEn   = p[0];
    twoStop    = s[0];
    tracking = 1'b0; seenLow = 1'b0; lowTicks = 0; preTicks = 0; doneCnt = 0;
    badDone = 0; riseNoDone = 0; lateChange = 0;
    pulseCmd();
    tracking = 1'b1;
    if (n == 0) begin
      @(negedge clk);
      // R5: done in the cycle right after the command edge
      check(donePulse === 1'b1, "R5 done after empty command", int'(donePulse), 1);
      repeat (3 * TICK_DIV) @(negedge clk);
      check(!seenLow, "R5 line stays high", int'(seenLow), 0);
      check(doneCnt == 1, "R5 one done pulse", doneCnt, 1);
    end else begin
      if (mode == 1) pulseCmd();  // R6: while pending or just started
      guard = 0;
      while (!seenLow && guard < 100) begin @(negedge clk); guard++; end
      repeat (5) @(negedge clk);
      if (mode == 1) pulseCmd();  // R6: mid-break
      if (mode == 2) begin        // R7: change all inputs mid-break
        @(posedge clk); #2;
        breakCount = CNT_W'(n + 5);
        dataLen    = DLEN_W'((dl == 5) ? 14 : 5);
        parityEn   = ~p[0];
        twoStop    = ~s[0];
      end
      guard = 0;
      while (doneCnt == 0 && guard < 3000) begin @(negedge clk); guard++; end
      repeat (3 * TICK_DIV) @(negedge clk);
      check(preTicks == 1, "R2 one tick before line falls", preTicks, 1);
      check(lowTicks == n * expLen,
            (mode == 2) ? "R7 length from sampled inputs" :
            (mode == 1) ? "R6 length kept under extra command" : "R3 low ticks",
            lowTicks, n * expLen);
      check(doneCnt == 1, (mode == 1) ? "R6 single done" : "R4 single done", doneCnt, 1);
      check(badDone == 0 && riseNoDone == 0, "R4 done coincides with release", badDone + riseNoDone, 0);
      check(txLine === 1'b1, "R1 line idle after break", int'(txLine), 1);
    end
    check(lateChange == 0, "R8 line moves only on ticks", lateChange, 0);
    tracking = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(txLine === 1'b1, "R1 reset line high", int'(txLine), 1);
    check(donePulse === 1'b0, "R1 reset done low", int'(donePulse), 0);
    for (int n = 0; n <= 3; n++)
      for (int dl = 5; dl <= 14; dl++)
        for (int p = 0; p <= 1; p++)
          for (int s = 0; s <= 1; s++)
            runBreak(n, dl, p, s, 0);
    runBreak(2, 8, 0, 0, 1);
    runBreak(1, 14, 1, 1, 1);
    runBreak(3, 5, 0, 0, 1);
    runBreak(2, 8, 0, 0, 2);
    runBreak(1, 5, 1, 1, 2);
    runBreak(3, 14, 0, 1, 2);
    runBreak(20, 7, 1, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule